// File: doc/BRIEF.md
# Buffered Channel Pair Handshake Controller

This block runs one input channel and one output channel of a cable group. Each side moves a block of 48-bit words to or from external equipment. It uses a four-phase level handshake: a ready line from the sender and a resume line from the receiver. Software, or a sequencer, starts a side by pulsing its start input together with a word count. That side then raises its buffer-active line and holds it until the last word's handshake has closed.

For every word the block raises a one-cycle request towards a storage scanner and waits for the grant. On the input side the grant means the latched word has been taken by storage. On the output side the grant comes with the word that storage supplies, and the block drives that word onto the data lines. It raises output ready only after a settling delay, counted in clock cycles, has passed. The ready and resume lines that come from the equipment pass through two-flop synchronizers. A master clear input returns both sides to idle at once.

Top module: `chan_pair_hs`

## Requirements
- R1: After a start with a nonzero count, `in_active` is high at the next sampling point. It stays high until the resume of the final input word has fallen, and it falls on the same clock edge as that resume.
- R2: When the synchronized input ready is seen, the block latches all 48 data bits. This includes any high-order bits that short-word equipment drives to one. The block then pulses `in_req` for exactly one cycle with `in_word` holding the latched word.
- R3: `in_resume` rises on the edge at which the grant is sampled. It stays high while the synchronized input ready is high, and it falls on the edge at which that ready is seen low.
- R4: Each output word starts with a one-cycle `out_req` pulse. The word present on `out_src_word` together with the grant is then driven on `out_data`, and the equipment receives it unchanged.
- R5: `out_rdy` rises exactly `SETTLE_CYC` clock edges after `out_data` changes, and `out_data` does not change while `out_rdy` is high.
- R6: `out_rdy` falls on the edge at which the synchronized output resume is seen high. The next word is not requested until that resume is seen low again.
- R7: `out_active` is high from the start until the resume of the final output word has dropped. It falls on the edge at which that drop is seen, and `out_rdy` is never high while `out_active` is low.
- R8: A start pulse on a side that is already active is ignored, and so is a start with a count of zero. The block length and the active line are unaffected.
- R9: A master clear drives both active lines, both resumes and ready lines, and both requests low by the next edge.
- R10: A change on an equipment ready or resume input acts on the state machine on the third clock edge after it is applied, because of the two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mclr | input | 1 | Master clear, returns both sides to idle |
| in_start | input | 1 | Start pulse for the input side |
| in_len | input | CNT_W | Number of words in the input block |
| in_data_ext | input | WORD_W | Input data lines from the equipment |
| in_rdy_ext | input | 1 | Input data ready from the equipment |
| in_gnt | input | 1 | Scanner grant for the input side |
| in_active | output | 1 | Input buffer active |
| in_resume | output | 1 | Input data resume to the equipment |
| in_req | output | 1 | One-cycle request to the scanner for storing a word |
| in_word | output | WORD_W | Latched input word handed to storage |
| out_start | input | 1 | Start pulse for the output side |
| out_len | input | CNT_W | Number of words in the output block |
| out_gnt | input | 1 | Scanner grant for the output side |
| out_src_word | input | WORD_W | Word from storage, valid with out_gnt |
| out_resume_ext | input | 1 | Output data resume from the equipment |
| out_active | output | 1 | Output buffer active |
| out_req | output | 1 | One-cycle request to the scanner for fetching a word |
| out_data | output | WORD_W | Output data lines to the equipment |
| out_rdy | output | 1 | Output data ready to the equipment |

## Verification
Each result is due at a fixed cycle, and the bench checks it at exactly that count of negative edges after the stimulus. After input ready is raised, `in_req` appears at the third sampling point and `in_resume` at the fourth. After ready drops, `in_resume` falls at the third point. `out_rdy` follows a data change by exactly `SETTLE_CYC` points and falls three points after resume rises. The active lines fall three points after the final ready or resume drops. A monitor compares every `in_req` word and every delivered output word against queues that the driver tasks fill.

// File: rtl/chp_pkg.sv
package chp_pkg;

  typedef enum logic [2:0] {
    IS_IDLE,
    IS_WAIT_RDY,
    IS_WAIT_GNT,
    IS_WAIT_DROP
  } in_state_e;

  typedef enum logic [2:0] {
    OS_IDLE,
    OS_FETCH,
    OS_WAIT_GNT,
    OS_SETTLE,
    OS_WAIT_RES,
    OS_WAIT_RDROP
  } out_state_e;

endpackage

// File: rtl/chp_sync.sv
module chp_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [N-1:0] meta;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        meta[i] <= 1'b0;
        q[i]    <= 1'b0;
      end else begin
        meta[i] <= d[i];
        q[i]    <= meta[i];
      end
    end
  end

endmodule

// File: rtl/chp_in_side.sv
module chp_in_side
  import chp_pkg::*;
#(
  parameter int WORD_W = 48,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mclr,
  input  logic              start,
  input  logic [CNT_W-1:0]  len,
  input  logic              rdy_s,
  input  logic [WORD_W-1:0] data_ext,
  input  logic              gnt,
  output logic              active,
  output logic              resume,
  output logic              req,
  output logic [WORD_W-1:0] word
);

  in_state_e        st;
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst || mclr) begin
      st     <= IS_IDLE;
      left   <= '0;
      active <= 1'b0;
      resume <= 1'b0;
      req    <= 1'b0;
      word   <= '0;
    end else begin
      case (st)
        IS_IDLE: begin
          if (start && (len != '0)) begin
            left   <= len;
            active <= 1'b1;
            st     <= IS_WAIT_RDY;
          end
        end
        IS_WAIT_RDY: begin
          if (rdy_s) begin
            word <= data_ext;
            req  <= 1'b1;
            st   <= IS_WAIT_GNT;
          end
        end
        IS_WAIT_GNT: begin
          req <= 1'b0;
          if (gnt) begin
            resume <= 1'b1;
            left   <= left - CNT_W'(1);
            st     <= IS_WAIT_DROP;
          end
        end
        IS_WAIT_DROP: begin
          if (!rdy_s) begin
            resume <= 1'b0;
            if (left == '0) begin
              active <= 1'b0;
              st     <= IS_IDLE;
            end else begin
              st <= IS_WAIT_RDY;
            end
          end
        end
        default: st <= IS_IDLE;
      endcase
    end
  end

  AST_IN_REQ_PULSE: assert property (@(posedge clk) disable iff (rst || mclr)
    req |=> !req); // R2

  AST_IN_RESUME_AFTER_GNT: assert property (@(posedge clk) disable iff (rst || mclr)
    $rose(resume) |-> $past(gnt)); // R3

  AST_IN_RESUME_HELD: assert property (@(posedge clk) disable iff (rst || mclr)
    (resume && rdy_s) |=> resume); // R3

  AST_IN_RESUME_FRAMED: assert property (@(posedge clk) disable iff (rst || mclr)
    resume |-> active); // R1

endmodule

// File: rtl/chp_out_side.sv
module chp_out_side
  import chp_pkg::*;
#(
  parameter int WORD_W     = 48,
  parameter int CNT_W      = 16,
  parameter int SETTLE_CYC = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mclr,
  input  logic              start,
  input  logic [CNT_W-1:0]  len,
  input  logic              res_s,
  input  logic              gnt,
  input  logic [WORD_W-1:0] src_word,
  output logic              active,
  output logic              req,
  output logic [WORD_W-1:0] data,
  output logic              rdy
);

  localparam int SCW = $clog2(SETTLE_CYC + 1);

  out_state_e       st;
  logic [CNT_W-1:0] left;
  logic [SCW-1:0]   scnt;

  always_ff @(posedge clk) begin
    if (rst || mclr) begin
      st     <= OS_IDLE;
      left   <= '0;
      scnt   <= '0;
      active <= 1'b0;
      req    <= 1'b0;
      data   <= '0;
      rdy    <= 1'b0;
    end else begin
      case (st)
        OS_IDLE: begin
          if (start && (len != '0)) begin
            left   <= len;
            active <= 1'b1;
            st     <= OS_FETCH;
          end
        end
        OS_FETCH: begin
          req <= 1'b1;
          st  <= OS_WAIT_GNT;
        end
        OS_WAIT_GNT: begin
          req <= 1'b0;
          if (gnt) begin
            data <= src_word;
            scnt <= SCW'(SETTLE_CYC - 1);
            st   <= OS_SETTLE;
          end
        end
        OS_SETTLE: begin
          if (scnt == '0) begin
            rdy <= 1'b1;
            st  <= OS_WAIT_RES;
          end else begin
            scnt <= scnt - SCW'(1);
          end
        end
        OS_WAIT_RES: begin
          if (res_s) begin
            rdy  <= 1'b0;
            left <= left - CNT_W'(1);
            st   <= OS_WAIT_RDROP;
          end
        end
        OS_WAIT_RDROP: begin
          if (!res_s) begin
            if (left == '0) begin
              active <= 1'b0;
              st     <= OS_IDLE;
            end else begin
              st <= OS_FETCH;
            end
          end
        end
        default: st <= OS_IDLE;
      endcase
    end
  end

  AST_OUT_REQ_PULSE: assert property (@(posedge clk) disable iff (rst || mclr)
    req |=> !req); // R4

  AST_OUT_DATA_STABLE: assert property (@(posedge clk) disable iff (rst || mclr)
    rdy |-> $stable(data)); // R5

  AST_OUT_NO_FETCH_UNDER_RES: assert property (@(posedge clk) disable iff (rst || mclr)
    req |-> !res_s); // R6

  AST_OUT_RDY_FRAMED: assert property (@(posedge clk) disable iff (rst || mclr)
    rdy |-> active); // R7

endmodule

// File: rtl/chan_pair_hs.sv
module chan_pair_hs #(
  parameter int WORD_W     = 48,
  parameter int CNT_W      = 16,
  parameter int SETTLE_CYC = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mclr,
  input  logic              in_start,
  input  logic [CNT_W-1:0]  in_len,
  input  logic [WORD_W-1:0] in_data_ext,
  input  logic              in_rdy_ext,
  input  logic              in_gnt,
  output logic              in_active,
  output logic              in_resume,
  output logic              in_req,
  output logic [WORD_W-1:0] in_word,
  input  logic              out_start,
  input  logic [CNT_W-1:0]  out_len,
  input  logic              out_gnt,
  input  logic [WORD_W-1:0] out_src_word,
  input  logic              out_resume_ext,
  output logic              out_active,
  output logic              out_req,
  output logic [WORD_W-1:0] out_data,
  output logic              out_rdy
);

  logic [1:0] ext_raw;
  logic [1:0] ext_s;

  assign ext_raw = {out_resume_ext, in_rdy_ext};

  chp_sync #(.N(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ext_raw),
    .q   (ext_s)
  );

  chp_in_side #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_in (
    .clk      (clk),
    .rst      (rst),
    .mclr     (mclr),
    .start    (in_start),
    .len      (in_len),
    .rdy_s    (ext_s[0]),
    .data_ext (in_data_ext),
    .gnt      (in_gnt),
    .active   (in_active),
    .resume   (in_resume),
    .req      (in_req),
    .word     (in_word)
  );

  chp_out_side #(.WORD_W(WORD_W), .CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC)) u_out (
    .clk      (clk),
    .rst      (rst),
    .mclr     (mclr),
    .start    (out_start),
    .len      (out_len),
    .res_s    (ext_s[1]),
    .gnt      (out_gnt),
    .src_word (out_src_word),
    .active   (out_active),
    .req      (out_req),
    .data     (out_data),
    .rdy      (out_rdy)
  );

  AST_MCLR_IDLE: assert property (@(posedge clk) disable iff (rst)
    mclr |=> (!in_active && !out_active && !in_resume && !out_rdy && !in_req && !out_req)); // R9

endmodule

// File: tb/chan_pair_hs_test.sv
module chan_pair_hs_test;

  localparam int W      = 48;
  localparam int CW     = 16;
  localparam int SETTLE = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mclr = 1'b0;
  logic          in_start = 1'b0;
  logic [CW-1:0] in_len = '0;
  logic [W-1:0]  in_data_ext = '0;
  logic          in_rdy_ext = 1'b0;
  logic          in_gnt = 1'b0;
  logic          in_active, in_resume, in_req;
  logic [W-1:0]  in_word;
  logic          out_start = 1'b0;
  logic [CW-1:0] out_len = '0;
  logic          out_gnt = 1'b0;
  logic [W-1:0]  out_src_word = '0;
  logic          out_resume_ext = 1'b0;
  logic          out_active, out_req, out_rdy;
  logic [W-1:0]  out_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [W-1:0] exp_in[$];
  logic [W-1:0] src_q[$];
  logic [W-1:0] exp_out[$];

  chan_pair_hs #(.WORD_W(W), .CNT_W(CW), .SETTLE_CYC(SETTLE)) uut (
    .clk(clk), .rst(rst), .mclr(mclr),
    .in_start(in_start), .in_len(in_len), .in_data_ext(in_data_ext),
    .in_rdy_ext(in_rdy_ext), .in_gnt(in_gnt), .in_active(in_active),
    .in_resume(in_resume), .in_req(in_req), .in_word(in_word),
    .out_start(out_start), .out_len(out_len), .out_gnt(out_gnt),
    .out_src_word(out_src_word), .out_resume_ext(out_resume_ext),
    .out_active(out_active), .out_req(out_req), .out_data(out_data),
    .out_rdy(out_rdy)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    report();
  end

  // scanner model: grant one cycle after each request
  always @(negedge clk) begin
    in_gnt <= in_req;
    if (out_req && src_q.size() > 0) begin
      out_src_word <= src_q.pop_front();
      out_gnt <= 1'b1;
    end else begin
      out_gnt <= 1'b0;
    end
  end

  // input scoreboard monitor
  always @(negedge clk) begin
    if (in_req) begin
      if (exp_in.size() == 0) chk(0, "R2", "unexpected in_req", in_word, '0);
      else begin
        logic [W-1:0] e;
        e = exp_in.pop_front();
        chk(in_word == e, "R2", "stored word", in_word, e);
      end
    end
  end

  // settle-delay monitor
  int cyc = 0;
  int tchg = 0;
  logic [W-1:0] prev_data = '0;
  logic prev_rdy = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (out_data !== prev_data) tchg = cyc;
    if (out_rdy && !prev_rdy)
      chk((cyc - tchg) == SETTLE, "R5", "ready delay after data",
          W'(cyc - tchg), W'(SETTLE));
    prev_data = out_data;
    prev_rdy = out_rdy;
  end

  task automatic start_in(input int n);
    @(negedge clk);
    in_len = CW'(n);
    in_start = 1'b1;
    @(negedge clk);
    in_start = 1'b0;
  endtask

  task automatic start_out(input int n);
    @(negedge clk);
    out_len = CW'(n);
    out_start = 1'b1;
    @(negedge clk);
    out_start = 1'b0;
  endtask

  task automatic send_in(input logic [W-1:0] w, input bit last);
    int n;
    exp_in.push_back(w);
    @(negedge clk);
    in_data_ext = w;
    in_rdy_ext = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!in_req && n < 50);
    chk(n == 3, "R10", "ready-to-request points", W'(n), W'(3));
    n = 0;
    do begin @(negedge clk); n++; end while (!in_resume && n < 50);
    chk(n == 1, "R3", "grant-to-resume points", W'(n), W'(1));
    in_rdy_ext = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (in_resume && n < 50);
    chk(n == 3, "R3", "ready-drop-to-resume-drop points", W'(n), W'(3));
    chk(in_active == !last, "R1", "in_active after word", W'(in_active), W'(!last));
  endtask

  task automatic take_out(input bit last);
    int n;
    logic [W-1:0] e;
    n = 0;
    do begin @(negedge clk); n++; end while (!out_rdy && n < 200);
    e = (exp_out.size() > 0) ? exp_out.pop_front() : '0;
    chk(out_data == e, "R4", "delivered word", out_data, e);
    out_resume_ext = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (out_rdy && n < 50);
    chk(n == 3, "R6", "resume-to-ready-drop points", W'(n), W'(3));
    chk(!out_req, "R6", "no request while resume high", W'(out_req), '0);
    out_resume_ext = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_active == !last, "R7", "out_active after word", W'(out_active), W'(!last));
  endtask

  task automatic push_out(input logic [W-1:0] w);
    src_q.push_back(w);
    exp_out.push_back(w);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!in_active && !in_resume && !in_req, "R1", "input idle after reset",
        W'({in_active, in_resume, in_req}), '0);
    chk(!out_active && !out_rdy && !out_req, "R7", "output idle after reset",
        W'({out_active, out_rdy, out_req}), '0);

    // zero-length start is ignored
    start_in(0);
    chk(!in_active, "R8", "zero-length start", W'(in_active), '0);

    // input block of 3, with a stray start mid-block
    start_in(3);
    chk(in_active, "R1", "in_active after start", W'(in_active), W'(1));
    send_in(48'hFFFF_FF00_1234, 0);
    start_in(7);
    send_in(48'h8000_0000_0001, 0);
    send_in(48'h1234_5678_9ABC, 1);
    repeat (8) @(negedge clk);
    chk(!in_active && !in_req, "R8", "stray start did not extend block",
        W'({in_active, in_req}), '0);

    // output block of 3
    push_out(48'hA5A5_0000_FFFF);
    push_out(48'h0000_0000_0001);
    push_out(48'hFFFF_FFFF_FFFF);
    start_out(3);
    chk(out_active, "R7", "out_active after start", W'(out_active), W'(1));
    take_out(0);
    take_out(0);
    take_out(1);

    // both sides concurrently
    push_out(48'h0F0F_0F0F_0F0F);
    push_out(48'hF0F0_F0F0_F0F0);
    fork
      begin
        start_in(2);
        send_in(48'h0000_0000_00FF, 0);
        send_in(48'hFFFF_FFFF_FFFE, 1);
      end
      begin
        start_out(2);
        take_out(0);
        take_out(1);
      end
    join

    // master clear with both sides mid-handshake
    src_q.push_back(48'h1111_2222_3333);
    start_out(2);
    start_in(4);
    exp_in.push_back(48'h4444_5555_6666);
    @(negedge clk);
    in_data_ext = 48'h4444_5555_6666;
    in_rdy_ext = 1'b1;
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!(out_rdy && in_resume) && n < 200);
    end
    mclr = 1'b1;
    @(negedge clk);
    mclr = 1'b0;
    chk(!in_active && !in_resume && !in_req, "R9", "input cleared",
        W'({in_active, in_resume, in_req}), '0);
    chk(!out_active && !out_rdy && !out_req, "R9", "output cleared",
        W'({out_active, out_rdy, out_req}), '0);
    in_rdy_ext = 1'b0;
    repeat (6) @(negedge clk);
    chk(!in_active && !out_active, "R9", "stays idle after clear",
        W'({in_active, out_active}), '0);
    chk(exp_in.size() == 0, "R2", "all input words stored", W'(exp_in.size()), '0);
    report();
  end

endmodule